// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order integer pipeline has to wait one cycle. The only case that needs a wait is a load in the execute stage whose destination register is a source of the instruction in decode. Results from ALU instructions are handled by forwarding elsewhere, so they never cause a wait here.

The decision comes straight from the current latch contents, with no register on the way. It compares the two 5-bit source specifiers of the decode instruction with the destination specifier of the execute instruction. Each comparison counts only when the source is really read and the producer really writes a register. Register zero is hardwired to zero and never matches.

On a wait, the block holds the program counter and the fetch/decode latch and selects a bubble into the execute stage. On the next cycle the load has moved to the memory stage, so the same check no longer fires and the pipeline resumes. Forwarding then supplies the loaded value.

Top module: `hazInterlock`

## Requirements
- R1: A stall is raised in the same cycle when the execute instruction is a register-writing load (exMemRead=1, exRegWrite=1) and its nonzero destination equals decSrcA with decUseA=1, or equals decSrcB with decUseB=1.
- R2: While a stall is raised, pcWriteEn=0, ifIdWriteEn=0 and bubbleSel=1. Otherwise pcWriteEn=1, ifIdWriteEn=1 and bubbleSel=0.
- R3: A destination of register 0 never raises a stall, whatever the source fields are.
- R4: An execute instruction with exMemRead=0 never raises a stall, because ALU results are forwarded.
- R5: An execute instruction with exRegWrite=0, such as a store, never raises a stall.
- R6: A source whose use flag is 0 takes no part in the comparison.
- R7: In a running pipeline, a load followed directly by a dependent instruction costs exactly one stall cycle. The held instruction then passes on the next cycle while a bubble occupies execute. Independent loads and store-then-read pairs cost no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rstN | input | 1 | Active-low reset, disables the embedded checks |
| decSrcA | input | 5 | First source specifier of the decode instruction |
| decSrcB | input | 5 | Second source specifier of the decode instruction |
| decUseA | input | 1 | Decode instruction reads its first source |
| decUseB | input | 1 | Decode instruction reads its second source |
| exDest | input | 5 | Destination specifier of the execute instruction |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exMemRead | input | 1 | Execute instruction is a load |
| pcWriteEn | output | 1 | Program counter update enable |
| ifIdWriteEn | output | 1 | Fetch/decode latch update enable |
| bubbleSel | output | 1 | Selects a cleared control word into execute |

## Verification
In one cycle, both source comparators can match the same load destination. At the same time the zero-register exclusion or a cleared use flag can veto one or both matches. The random stimulus biases the source fields toward the execute destination and includes register 0 often, so these overlaps occur many times. Each outcome is judged against a bench function built from R1 and R3 to R6. A small pipeline model in the bench also runs instruction sequences through the block and checks that the stall count and the bubble placement follow R7.

// File: rtl/hazPkg.sv
package hazPkg;
  localparam int REG_W   = 5;
  localparam int NUM_SRC = 2;

  typedef struct packed {
    logic holdPc;
    logic holdIfId;
    logic bubble;
  } stallStrobes_t;
endpackage

// File: rtl/hazCompare.sv
module hazCompare #(
  parameter int REG_W   = hazPkg::REG_W,
  parameter int NUM_SRC = hazPkg::NUM_SRC
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   srcReg,
  input  logic [NUM_SRC-1:0]              srcUsed,
  input  logic [REG_W-1:0]                dstReg,
  output logic [NUM_SRC-1:0]              srcHit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic dstLive;
  assign dstLive = (dstReg != ZERO_REG);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic specEq;
    assign specEq    = (dstReg == srcReg[i]);
    assign srcHit[i] = srcUsed[i] & specEq & dstLive;

    // R6: an unread source never reports a match
    a_r6_unused_source: assert property (@(posedge clk) disable iff (!rstN)
      !srcUsed[i] |-> !srcHit[i]);
  end
endmodule

// File: rtl/hazControl.sv
module hazControl #(
  parameter int NUM_SRC = hazPkg::NUM_SRC
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_SRC-1:0]       srcHit,
  input  logic                     exMemRead,
  input  logic                     exRegWrite,
  output hazPkg::stallStrobes_t    strb
);
  logic loadWrites;
  logic stallNow;

  assign loadWrites = exMemRead & exRegWrite;
  assign stallNow   = loadWrites & (|srcHit);

  always_comb begin
    strb          = '0;
    strb.holdPc   = stallNow;
    strb.holdIfId = stallNow;
    strb.bubble   = stallNow;
  end

  // R4: a non-load producer never stalls
  a_r4_alu_forwarded: assert property (@(posedge clk) disable iff (!rstN)
    !exMemRead |-> !strb.bubble);
endmodule

// File: rtl/hazInterlock.sv
module hazInterlock #(
  parameter int REG_W = hazPkg::REG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] decSrcA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic             decUseA,
  input  logic             decUseB,
  input  logic [REG_W-1:0] exDest,
  input  logic             exRegWrite,
  input  logic             exMemRead,
  output logic             pcWriteEn,
  output logic             ifIdWriteEn,
  output logic             bubbleSel
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] srcReg;
  logic [NSRC-1:0]            srcUsed;
  logic [NSRC-1:0]            srcHit;
  hazPkg::stallStrobes_t      strb;

  assign srcReg  = {decSrcB, decSrcA};
  assign srcUsed = {decUseB, decUseA};

  hazCompare #(.REG_W(REG_W), .NUM_SRC(NSRC)) u_cmp (
    .clk(clk), .rstN(rstN), .srcReg(srcReg), .srcUsed(srcUsed),
    .dstReg(exDest), .srcHit(srcHit)
  );

  hazControl #(.NUM_SRC(NSRC)) u_ctl (
    .clk(clk), .rstN(rstN), .srcHit(srcHit),
    .exMemRead(exMemRead), .exRegWrite(exRegWrite), .strb(strb)
  );

  assign pcWriteEn   = ~strb.holdPc;
  assign ifIdWriteEn = ~strb.holdIfId;
  assign bubbleSel   = strb.bubble;

  // R2: the three strobes always move together
  a_r2_strobes_agree: assert property (@(posedge clk) disable iff (!rstN)
    (pcWriteEn == ifIdWriteEn) && (bubbleSel == !pcWriteEn));
  // R3: destination zero never stalls
  a_r3_zero_dest: assert property (@(posedge clk) disable iff (!rstN)
    (exDest == '0) |-> pcWriteEn);
  // R5: a non-writing producer never stalls
  a_r5_store_free: assert property (@(posedge clk) disable iff (!rstN)
    !exRegWrite |-> !bubbleSel);
  // R1: a used source matching a live load destination stalls
  a_r1_dep_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (exMemRead && exRegWrite && exDest != '0 &&
     ((decUseA && decSrcA == exDest) || (decUseB && decSrcB == exDest)))
    |-> bubbleSel);
endmodule

// File: tb/test_hazInterlock.sv
module test_hazInterlock;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] decSrcA = '0, decSrcB = '0, exDest = '0;
  logic       decUseA = 1'b0, decUseB = 1'b0, exRegWrite = 1'b0, exMemRead = 1'b0;
  logic       pcWriteEn, ifIdWriteEn, bubbleSel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  hazInterlock i_hazInterlock (
    .clk(clk), .rstN(rstN), .decSrcA(decSrcA), .decSrcB(decSrcB),
    .decUseA(decUseA), .decUseB(decUseB), .exDest(exDest),
    .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .pcWriteEn(pcWriteEn), .ifIdWriteEn(ifIdWriteEn), .bubbleSel(bubbleSel)
  );

  typedef struct packed {
    logic [4:0] dst; logic [4:0] sa; logic [4:0] sb;
    logic ua; logic ub; logic ld; logic wr;
  } instr_t;

  localparam instr_t NOP = '0;

  function automatic logic expStall(logic [4:0] sa, logic [4:0] sb, logic ua,
                                    logic ub, logic [4:0] d, logic wr, logic ld);
    if (!ld || !wr || d == 5'd0) return 1'b0;
    return (ua && sa == d) || (ub && sb == d);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOut(string req, logic st);
    check({req, " pcWriteEn"}, pcWriteEn, !st);
    check({req, " ifIdWriteEn"}, ifIdWriteEn, !st);
    check({req, " bubbleSel"}, bubbleSel, st);
  endtask

  task automatic apply(string req, logic [4:0] sa, logic [4:0] sb, logic ua,
                       logic ub, logic [4:0] d, logic wr, logic ld);
    @(posedge clk); #1;
    decSrcA = sa; decSrcB = sb; decUseA = ua; decUseB = ub;
    exDest = d; exRegWrite = wr; exMemRead = ld;
    @(negedge clk);
    checkOut(req, expStall(sa, sb, ua, ub, d, wr, ld));
  endtask

  // Runs a two-instruction program through a bench pipeline model (R7)
  task automatic runPair(string req, instr_t first, instr_t second, int expStalls);
    instr_t prog[3];
    instr_t exSlot;
    int idx = 0;
    int stalls = 0;
    int bubbleOk = 1;
    logic prevStall = 1'b0;
    prog[0] = first; prog[1] = second; prog[2] = NOP;
    exSlot = NOP;
    for (int c = 0; c < 6; c++) begin
      @(posedge clk); #1;
      decSrcA = prog[idx].sa; decSrcB = prog[idx].sb;
      decUseA = prog[idx].ua; decUseB = prog[idx].ub;
      exDest = exSlot.dst; exRegWrite = exSlot.wr; exMemRead = exSlot.ld;
      @(negedge clk);
      if (prevStall && (exSlot != NOP || bubbleSel)) bubbleOk = 0;
      prevStall = bubbleSel;
      if (bubbleSel) begin
        stalls++;
        exSlot = NOP;
      end else begin
        exSlot = prog[idx];
        if (idx < 2) idx++;
      end
    end
    check({req, " stall cycles"}, stalls, expStalls);
    check({req, " bubble then resume"}, bubbleOk, 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    instr_t ldR5, useR5, useR5b, indep, stR5, ldR0, useR0, immR5;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkOut("R2 reset idle", 1'b0);
    rstN = 1'b1;

    // Directed corners
    apply("R1 srcA match", 5'd7, 5'd2, 1, 1, 5'd7, 1, 1);
    apply("R1 srcB match", 5'd3, 5'd9, 1, 1, 5'd9, 1, 1);
    apply("R1 both match", 5'd4, 5'd4, 1, 1, 5'd4, 1, 1);
    apply("R3 zero dest", 5'd0, 5'd0, 1, 1, 5'd0, 1, 1);
    apply("R4 alu producer", 5'd6, 5'd6, 1, 1, 5'd6, 1, 0);
    apply("R5 store producer", 5'd8, 5'd8, 1, 1, 5'd8, 0, 1);
    apply("R6 srcA unused", 5'd11, 5'd1, 0, 1, 5'd11, 1, 1);
    apply("R6 srcB unused", 5'd1, 5'd12, 1, 0, 5'd12, 1, 1);
    apply("R6 srcA unused srcB live", 5'd13, 5'd13, 0, 1, 5'd13, 1, 1);

    // Random stimulus biased toward matches
    for (int n = 0; n < 400; n++) begin
      logic [4:0] d, sa, sb;
      d  = 5'($urandom_range(0, 7));
      sa = ($urandom_range(0, 2) == 0) ? 5'($urandom) : d;
      sb = ($urandom_range(0, 2) == 0) ? 5'($urandom) : d;
      apply("R1 R3 R4 R5 R6 random", sa, sb, 1'($urandom), 1'($urandom),
            d, 1'($urandom), 1'($urandom));
    end

    // Sequences (R7)
    ldR5   = '{dst:5'd5, sa:5'd1, sb:5'd0, ua:1, ub:0, ld:1, wr:1};
    useR5  = '{dst:5'd6, sa:5'd5, sb:5'd2, ua:1, ub:1, ld:0, wr:1};
    useR5b = '{dst:5'd6, sa:5'd2, sb:5'd5, ua:1, ub:1, ld:0, wr:1};
    indep  = '{dst:5'd6, sa:5'd2, sb:5'd3, ua:1, ub:1, ld:0, wr:1};
    stR5   = '{dst:5'd5, sa:5'd1, sb:5'd9, ua:1, ub:1, ld:0, wr:0};
    ldR0   = '{dst:5'd0, sa:5'd1, sb:5'd0, ua:1, ub:0, ld:1, wr:1};
    useR0  = '{dst:5'd6, sa:5'd0, sb:5'd0, ua:1, ub:1, ld:0, wr:1};
    immR5  = '{dst:5'd6, sa:5'd2, sb:5'd5, ua:1, ub:0, ld:0, wr:1};
    runPair("R7 load then srcA use", ldR5, useR5, 1);
    runPair("R7 load then srcB use", ldR5, useR5b, 1);
    runPair("R7 load then independent", ldR5, indep, 0);
    runPair("R7 store then read", stR5, useR5, 0);
    runPair("R7 load r0 then read r0", ldR0, useR0, 0);
    runPair("R7 load then immediate form", ldR5, immR5, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule